// File: doc/BRIEF.md
# Cascaded Prioritized Interrupt Controller

This block joins two eight-line interrupt units into one fifteen-line request controller. The second unit (the "slave") reports its best request to the first unit (the "master") on master input 2, so master input 2 carries no device and the slave's lines are numbered 8 to 15. A device wired to the legacy line 2 input is steered onto slave input 1 and is serviced as line 9. Rising edges on the request lines are latched as pending. A per-line disable mask holds pending lines back, and a fixed priority picks the one to offer the CPU together with its vector number.

The CPU sees the offered interrupt as a stream: `int_valid` with `int_vector`, accepted by `int_ready`. Back-pressure is unlimited: while `int_ready` is low nothing changes state and the offer stays up. The offer is not frozen, though. A newly arrived higher-priority line replaces the vector before acceptance, and a mask write or end-of-interrupt may withdraw it. A transfer happens only in a cycle with `int_valid` and `int_ready` both high. Software drives each unit through two byte-wide I/O ports: a command/status port (writes are commands, reads return status) and a mask port.

Top module: `irq_pair_ctrl`

## Requirements
- R1: After reset no interrupt is offered, both pending and in-service registers read zero, and both mask registers read FFh (every line disabled).
- R2: A rising edge on a request line sets that line's pending bit, which shows in the status read (bit n of the master for line n, bit n-8 of the slave for line n) from the cycle after the edge.
- R3: A mask bit of 1 disables its line and 0 enables it. A masked pending line stays pending and is offered once unmasked. Masking master bit 2 holds back every slave line.
- R4: Priority is fixed: line 0 is highest, then 1, then slave lines 8 to 15 in that order, then master lines 3 to 7.
- R5: An offered master line n carries vector 08h+n, and slave line 8+k carries 70h+k. While unaccepted, a higher-priority arrival replaces the vector.
- R6: A rising edge on legacy input 2 behaves exactly like line 9 (vector 71h). Vector 0Ah is never offered.
- R7: Acceptance clears the line's pending bit and sets its in-service bit. For a slave line both master in-service bit 2 and slave bit k are set.
- R8: A pending line is not offered while its own in-service bit or any higher-priority in-service bit of the same unit is set. A higher-priority line is still offered (nesting).
- R9: Writing command 20h to a unit's command port clears only that unit's highest-priority in-service bit. A slave line needs this command on both units before lower slave lines are offered again.
- R10: Command 0Bh makes the unit's status read return in-service bits, command 0Ah returns to pending bits (the reset choice). Other command values change nothing.
- R11: The master answers at ports 20h (command/status) and 21h (mask), the slave at A0h and A1h. Reads elsewhere, or with `io_rd` low, return 00h. Writes elsewhere change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines 0..15. Bit 2 is the legacy line that is steered to line 9 |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read enable; `io_rdata` is valid in the same cycle |
| io_wdata | input | 8 | Write data (command byte or mask) |
| io_rdata | output | 8 | Read data (status or mask) |
| int_valid | output | 1 | An interrupt is offered |
| int_ready | input | 1 | CPU accepts the offered interrupt |
| int_vector | output | 8 | Vector number of the offered interrupt |

## Verification
The bench builds the block with its default parameters: eight lines per unit, the cascade on master input 2, the legacy line steered to slave input 1, vector bases 08h and 70h, and ports 20h/21h and A0h/A1h. With these values every one of the fifteen usable lines can be reached. The bench covers the position of the slave group between lines 1 and 3, the legacy line's reroute, the split command/status port, and the two-step end-of-interrupt for slave lines, using exactly the numbers the requirements state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [7:0] CMD_EOI     = 8'h20;
  localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
  localparam logic [7:0] CMD_SEL_ISR = 8'h0B;

  typedef enum logic { RD_PEND = 1'b0, RD_INSV = 1'b1 } rd_sel_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Lowest set index wins (index 0 = highest priority).
module irq_prio_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_unit.sv
// One eight-line unit: edge latch, mask, in-service tracking, selection.
module irq_unit
  import irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  edge_src,
  input  logic [N-1:0]  lvl_src,
  input  logic          wr_cmd,
  input  logic          wr_mask,
  input  logic [DW-1:0] wdata,
  input  logic          ack,
  output logic          out_req,
  output logic [IW-1:0] out_idx,
  output logic [N-1:0]  isr,
  output logic [N-1:0]  imr,
  output logic [DW-1:0] status
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  irr;
  logic [N-1:0]  src_q;
  rd_sel_e       rd_sel;

  logic [N-1:0]  rise;
  logic [N-1:0]  cand;
  logic          c_any, s_any;
  logic [IW-1:0] c_idx, s_idx;
  logic [N-1:0]  ack_hit, eoi_hit;
  logic          do_eoi;

  assign rise = edge_src & ~src_q;
  assign cand = (irr | lvl_src) & ~imr;

  irq_prio_pick #(.N(N)) u_pick_cand (.vec(cand), .any(c_any), .idx(c_idx));
  irq_prio_pick #(.N(N)) u_pick_insv (.vec(isr),  .any(s_any), .idx(s_idx));

  // Offer only if nothing of equal or higher priority is in service.
  assign out_req = c_any && (!s_any || (c_idx < s_idx));
  assign out_idx = c_idx;

  assign do_eoi  = wr_cmd && (wdata == DW'(CMD_EOI)) && s_any;
  assign ack_hit = (ack && out_req) ? (ONE << c_idx) : '0;
  assign eoi_hit = do_eoi ? (ONE << s_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      irr    <= '0;
      isr    <= '0;
      imr    <= '1;
      rd_sel <= RD_PEND;
    end else begin
      src_q <= edge_src;
      irr   <= (irr & ~ack_hit) | rise;
      isr   <= (isr & ~eoi_hit) | ack_hit;
      if (wr_mask) imr <= wdata[N-1:0];
      if (wr_cmd) begin
        if (wdata == DW'(CMD_SEL_ISR))      rd_sel <= RD_INSV;
        else if (wdata == DW'(CMD_SEL_IRR)) rd_sel <= RD_PEND;
      end
    end
  end

  assign status = (rd_sel == RD_INSV) ? DW'(isr) : DW'(irr);
endmodule

// File: rtl/irq_pair_ctrl.sv
// Master/slave pair with cascade on one master input and legacy reroute.
module irq_pair_ctrl #(
  parameter int          N           = 8,
  parameter int          DW          = 8,
  parameter int          AW          = 8,
  parameter int          VW          = 8,
  parameter int          CASCADE_IN  = 2,
  parameter int          LEGACY_DST  = 1,
  parameter logic [AW-1:0] MASTER_PORT = 8'h20,
  parameter logic [AW-1:0] SLAVE_PORT  = 8'hA0,
  parameter logic [VW-1:0] MASTER_BASE = 8'h08,
  parameter logic [VW-1:0] SLAVE_BASE  = 8'h70,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*N-1:0]  irq_in,
  input  logic [AW-1:0]   io_addr,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [DW-1:0]   io_wdata,
  output logic [DW-1:0]   io_rdata,
  output logic            int_valid,
  input  logic            int_ready,
  output logic [VW-1:0]   int_vector
);
  localparam logic [N-1:0]  CASC_BIT   = N'(1) << CASCADE_IN;
  localparam logic [N-1:0]  LEGACY_BIT = N'(1) << LEGACY_DST;
  localparam logic [AW-1:0] M_MASK_PORT = AW'(MASTER_PORT + 1);
  localparam logic [AW-1:0] S_MASK_PORT = AW'(SLAVE_PORT + 1);

  logic [N-1:0]  m_edge, s_edge, m_lvl;
  logic          m_req, s_req;
  logic [IW-1:0] m_idx, s_idx;
  logic [N-1:0]  m_isr, s_isr, m_imr, s_imr;
  logic [DW-1:0] m_status, s_status;
  logic          take, m_on_casc;

  // Master input at the cascade position carries no device.
  assign m_edge = irq_in[N-1:0] & ~CASC_BIT;
  // Legacy line is steered onto the slave.
  assign s_edge = irq_in[2*N-1:N] | (irq_in[CASCADE_IN] ? LEGACY_BIT : '0);
  assign m_lvl  = s_req ? CASC_BIT : '0;

  assign take      = int_valid && int_ready;
  assign m_on_casc = (m_idx == IW'(CASCADE_IN));

  irq_unit #(.N(N), .DW(DW)) u_master (
    .clk(clk), .rst_n(rst_n),
    .edge_src(m_edge), .lvl_src(m_lvl),
    .wr_cmd(io_wr && (io_addr == MASTER_PORT)),
    .wr_mask(io_wr && (io_addr == M_MASK_PORT)),
    .wdata(io_wdata), .ack(take),
    .out_req(m_req), .out_idx(m_idx),
    .isr(m_isr), .imr(m_imr), .status(m_status)
  );

  irq_unit #(.N(N), .DW(DW)) u_slave (
    .clk(clk), .rst_n(rst_n),
    .edge_src(s_edge), .lvl_src('0),
    .wr_cmd(io_wr && (io_addr == SLAVE_PORT)),
    .wr_mask(io_wr && (io_addr == S_MASK_PORT)),
    .wdata(io_wdata), .ack(take && m_on_casc),
    .out_req(s_req), .out_idx(s_idx),
    .isr(s_isr), .imr(s_imr), .status(s_status)
  );

  assign int_valid  = m_req;
  assign int_vector = m_on_casc ? (SLAVE_BASE + VW'(s_idx))
                                : (MASTER_BASE + VW'(m_idx));

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (io_addr == MASTER_PORT)      io_rdata = m_status;
      else if (io_addr == M_MASK_PORT) io_rdata = DW'(m_imr);
      else if (io_addr == SLAVE_PORT)  io_rdata = s_status;
      else if (io_addr == S_MASK_PORT) io_rdata = DW'(s_imr);
    end
  end
endmodule

// File: rtl/irq_pair_chk.sv
module irq_pair_chk #(
  parameter int N = 8,
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int VW = 8,
  parameter int CASCADE_IN = 2,
  parameter logic [AW-1:0] MASTER_PORT = 8'h20,
  parameter logic [VW-1:0] MASTER_BASE = 8'h08,
  parameter logic [VW-1:0] SLAVE_BASE  = 8'h70
) (
  input logic          clk,
  input logic          rst_n,
  input logic          int_valid,
  input logic          int_ready,
  input logic [VW-1:0] int_vector,
  input logic [AW-1:0] io_addr,
  input logic          io_wr,
  input logic [DW-1:0] io_wdata,
  input logic [N-1:0]  m_isr,
  input logic [N-1:0]  s_isr,
  input logic [N-1:0]  m_imr
);
  localparam logic [VW-1:0] M_HI   = VW'(MASTER_BASE + N);
  localparam logic [VW-1:0] S_HI   = VW'(SLAVE_BASE + N);
  localparam logic [VW-1:0] CASC_V = VW'(MASTER_BASE + CASCADE_IN);
  localparam logic [DW-1:0] EOI    = DW'(8'h20);

  logic take, m_eoi, in_m, in_s;
  assign take  = int_valid && int_ready;
  assign m_eoi = io_wr && (io_addr == MASTER_PORT) && (io_wdata == EOI);
  assign in_m  = (int_vector >= MASTER_BASE) && (int_vector < M_HI);
  assign in_s  = (int_vector >= SLAVE_BASE) && (int_vector < S_HI);

  assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> ((in_m && int_vector != CASC_V) || in_s));

  assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && in_m) |-> !m_imr[int_vector[2:0]]);

  assert_take_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !m_eoi) |=> ($countones(m_isr) == $past($countones(m_isr)) + 1));

  assert_slave_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_s) |=> s_isr[$past(int_vector[2:0])]);

  assert_eoi_one_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eoi && !take && (m_isr != '0)) |=>
      ($countones(m_isr) + 1 == $past($countones(m_isr))));
endmodule

bind irq_pair_ctrl irq_pair_chk #(
  .N(N), .AW(AW), .DW(DW), .VW(VW), .CASCADE_IN(CASCADE_IN),
  .MASTER_PORT(MASTER_PORT), .MASTER_BASE(MASTER_BASE), .SLAVE_BASE(SLAVE_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .int_valid(int_valid), .int_ready(int_ready),
  .int_vector(int_vector), .io_addr(io_addr), .io_wr(io_wr),
  .io_wdata(io_wdata), .m_isr(m_isr), .s_isr(s_isr), .m_imr(m_imr)
);

// File: tb/irq_pair_ctrl_test.sv
`timescale 1ns/1ps
module irq_pair_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        int_valid;
  logic        int_ready = 1'b0;
  logic [7:0]  int_vector;

  int total = 0, bad = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;   // 50 MHz

  irq_pair_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .int_valid(int_valid), .int_ready(int_ready), .int_vector(int_vector)
  );

  // {lines pulsed together, expected vector}
  localparam logic [23:0] TBL [10] = '{
    {16'h0001, 8'h08},   // R4 line 0
    {16'h0080, 8'h0F},   // R5 line 7
    {16'h8000, 8'h77},   // R5 line 15
    {16'h0100, 8'h70},   // R5 line 8
    {16'h0102, 8'h09},   // R4 line 1 over slave
    {16'h1008, 8'h74},   // R4 slave over line 3
    {16'h0004, 8'h71},   // R6 legacy line
    {16'h7000, 8'h74},   // R4 slave order
    {16'h0060, 8'h0D},   // R4 master order
    {16'h0208, 8'h71}    // R4 line 9 over line 3
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0; #1;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1; #1 d = io_rdata; io_rd = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk); irq_in = '0; #1;
  endtask

  task automatic accept(output logic [7:0] v);
    @(negedge clk); int_ready = 1'b1; #1 v = int_vector;
    @(negedge clk); int_ready = 1'b0; #1;
  endtask

  task automatic drain();
    logic [7:0] v;
    for (int k = 0; k < 20 && int_valid; k++) begin
      accept(v);
      io_write(8'h20, 8'h20);
      io_write(8'hA0, 8'h20);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    check("R1 valid", 16'(int_valid), 16'h0);
    io_read(8'h20, rd); check("R1 master pend", 16'(rd), 16'h00);
    io_read(8'h21, rd); check("R1 master mask", 16'(rd), 16'hFF);
    io_read(8'hA0, rd); check("R1 slave pend", 16'(rd), 16'h00);
    io_read(8'hA1, rd); check("R1 slave mask", 16'(rd), 16'hFF);

    // R2 latch while masked, R3 held until unmasked
    pulse(16'h0010);
    io_read(8'h20, rd); check("R2 pend bit4", 16'(rd), 16'h10);
    check("R3 masked no offer", 16'(int_valid), 16'h0);
    io_write(8'h21, 8'hEF);
    check("R3 unmask offers", {7'd0, int_valid, int_vector}, 16'h010C);
    accept(v); check("R5 accept vec", 16'(v), 16'h0C);
    io_read(8'h20, rd); check("R7 pend cleared", 16'(rd), 16'h00);
    io_write(8'h20, 8'h0B);
    io_read(8'h20, rd); check("R10 isr select", 16'(rd), 16'h10);
    io_write(8'h20, 8'h20);
    io_read(8'h20, rd); check("R9 eoi clears", 16'(rd), 16'h00);
    io_write(8'h20, 8'h0A);
    io_write(8'h21, 8'h00);
    io_write(8'hA1, 8'h00);

    // table walk: priority and vectors
    for (int i = 0; i < 10; i++) begin
      pulse(TBL[i][23:8]);
      check($sformatf("R4 table %0d", i), {7'd0, int_valid, int_vector},
            {7'd0, 1'b1, TBL[i][7:0]});
      drain();
    end

    // R8 nesting and blocking
    pulse(16'h0020); accept(v); check("R8 first", 16'(v), 16'h0D);
    pulse(16'h0040); check("R8 lower blocked", 16'(int_valid), 16'h0);
    pulse(16'h0002); check("R8 higher nests", {7'd0, int_valid, int_vector}, 16'h0109);
    accept(v);
    io_write(8'h20, 8'h0B);
    io_read(8'h20, rd); check("R8 isr nested", 16'(rd), 16'h22);
    io_write(8'h20, 8'h20);
    io_read(8'h20, rd); check("R9 highest only", 16'(rd), 16'h20);
    check("R8 still blocked", 16'(int_valid), 16'h0);
    io_write(8'h20, 8'h20);
    check("R8 released", {7'd0, int_valid, int_vector}, 16'h010E);
    drain();

    // R9 slave needs both EOIs; R7 both isr bits
    pulse(16'h0800); accept(v); check("R5 line 11", 16'(v), 16'h73);
    io_write(8'hA0, 8'h0B);
    io_read(8'h20, rd); check("R7 master casc isr", 16'(rd), 16'h04);
    io_read(8'hA0, rd); check("R7 slave isr", 16'(rd), 16'h08);
    io_write(8'h20, 8'h20);
    io_read(8'h20, rd); check("R9 master cleared", 16'(rd), 16'h00);
    io_read(8'hA0, rd); check("R9 slave kept", 16'(rd), 16'h08);
    pulse(16'h1000); check("R9 slave blocked", 16'(int_valid), 16'h0);
    io_write(8'hA0, 8'h20);
    check("R9 after both", {7'd0, int_valid, int_vector}, 16'h0174);
    drain();

    // R10 other command ignored
    io_write(8'hA0, 8'h55);
    io_read(8'hA0, rd); check("R10 ignored cmd", 16'(rd), 16'h00);
    pulse(16'h0200);
    io_read(8'hA0, rd); check("R10 still isr", 16'(rd), 16'h00);
    io_write(8'hA0, 8'h0A);
    io_read(8'hA0, rd); check("R10 back to pend", 16'(rd), 16'h02);
    drain();
    io_write(8'h20, 8'h0A);

    // R3 slave mask and master cascade mask
    io_write(8'hA1, 8'h01);
    pulse(16'h0100); check("R3 slave masked", 16'(int_valid), 16'h0);
    io_write(8'hA1, 8'h00);
    check("R3 slave unmasked", {7'd0, int_valid, int_vector}, 16'h0170);
    drain();
    io_write(8'h21, 8'h04);
    pulse(16'h0400); check("R3 casc masked", 16'(int_valid), 16'h0);
    io_write(8'h21, 8'h00);
    check("R3 casc unmasked", {7'd0, int_valid, int_vector}, 16'h0172);
    drain();

    // R5 vector replaced before acceptance
    pulse(16'h0080); check("R5 offer 7", {7'd0, int_valid, int_vector}, 16'h010F);
    pulse(16'h0001); check("R5 replaced", {7'd0, int_valid, int_vector}, 16'h0108);
    drain();

    // R11 port decode
    @(negedge clk); io_addr = 8'h21; io_rd = 1'b0; #1;
    check("R11 rd low", 16'(io_rdata), 16'h00);
    io_read(8'h22, rd); check("R11 other addr", 16'(rd), 16'h00);
    io_write(8'h22, 8'h5A);
    io_read(8'h21, rd); check("R11 mask untouched", 16'(rd), 16'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule